// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer Unit

The block is a register-mapped peripheral with four independent down-counters. Each counter has a start value, a readable current count, a control word and a staged reload value. A control word picks the enable, one of three prescale ratios, a 16-bit or 32-bit counting width, and one of three run styles: single-shot, periodic reload, or free-running wrap. Each counter raises a per-channel event when it expires. The events gather in a shared interrupt block that holds a sticky raw status, an enable mask, the masked view and a write-one-to-clear port. All of these drive one combined interrupt line.

Software writes a channel's start value and then its control word to arm it. The count falls by one on each prescaled tick. When a tick arrives while the count is already zero, the channel fires. A single-shot channel stays at zero and disarms itself. A periodic channel reloads from its staged value, which software may change at any time without disturbing the running count. A free-running channel wraps to the all-ones value of its width.

The bus is a plain synchronous port. A write takes effect at the clock edge on which it is presented. Read data for the presented address is registered and appears one cycle later.

Top module: `quad_dcount_timer`

## Requirements
- R1: Word addresses select the registers. Interrupt mask is at 0x00, raw status at 0x04, masked status at 0x08 and clear at 0x0C. Channel n (0..3) starts at 0x10+0x10*n: start value at +0x0, current count at +0x4, control at +0x8 and staged reload at +0xC. Read data is the addressed register as held at the clock edge after the address is presented. The start value address reads back the staged reload. The control word keeps only bits 7, 6, 3:2, 1 and 0, and the other bits read as zero.
- R2: Writing the start value sets both the current count and the staged reload to the written word.
- R3: When control bit 7 is 1, the count drops by one per prescaled tick. Control bits [3:2] set the prescale ratio: 00 gives 1, 01 gives 16, and 10 or 11 gives 256. The k-th tick falls on the k*ratio-th clock edge after the control write.
- R4: Periodic mode is bit 6 = 1 with bit 0 = 0. A tick that finds the count at zero reloads it from the staged value and fires the channel. Writing the staged reload at +0xC leaves the current count unchanged.
- R5: Free-running mode is bit 6 = 0 with bit 0 = 0. A tick that finds the count at zero wraps it to the all-ones value of the width and fires the channel.
- R6: Single-shot mode is bit 0 = 1, whatever the value of bit 6. A tick that finds the count at zero fires the channel, leaves the count at zero and clears control bit 7.
- R7: While control bit 7 is 0, the current count holds its value.
- R8: With control bit 1 = 0, only the low 16 bits of the count are used. The upper 16 bits read as zero and the wrap value is 0xFFFF. With bit 1 = 1, all 32 bits are used.
- R9: A firing of channel n sets raw status bit n on the next edge. Writing 1 to bit n of the clear register clears that bit, and a firing in the same cycle wins. Writes to the raw and masked addresses are ignored.
- R10: Masked status is the raw status ANDed with the mask register, where a 1 enables the channel. The interrupt line is high exactly when some masked bit is set.
- R11: After reset, every register reads zero and the interrupt line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register (word aligned) |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq_o | output | 1 | Combined interrupt line |

## Verification
Register writes land on the edge at which they are presented. A count's k-th tick falls k*ratio edges after the control write. A firing shows in raw status and on the interrupt line one edge after the tick that found zero. Read data trails the address by one edge. The bench arms a channel and then counts exactly m*ratio edges before sampling the interrupt line, so that line reflects ticks 1..m. The address of the current count is already presented at that point, so the next edge captures the count as it stood after tick m. That count is compared with an arithmetic prediction for each mode, width, prescale ratio and channel.

// File: rtl/qdt_pkg.sv
package qdt_pkg;

  // Control word bit positions (software-visible layout)
  localparam int unsigned CB_EN   = 7;
  localparam int unsigned CB_PER  = 6;
  localparam int unsigned CB_PSHI = 3;
  localparam int unsigned CB_PSLO = 2;
  localparam int unsigned CB_WIDE = 1;
  localparam int unsigned CB_ONE  = 0;
  localparam int unsigned CTRL_W  = 8;

  typedef struct packed {
    logic       en;
    logic       periodic;
    logic [1:0] presc;
    logic       wide;
    logic       oneshot;
  } ctrl_t;

  typedef enum logic [1:0] {
    CH_START  = 2'd0,
    CH_COUNT  = 2'd1,
    CH_CTRL   = 2'd2,
    CH_STAGED = 2'd3
  } ch_reg_e;

  typedef enum logic [1:0] {
    IR_MASK   = 2'd0,
    IR_RAW    = 2'd1,
    IR_MASKED = 2'd2,
    IR_CLEAR  = 2'd3
  } irq_reg_e;

endpackage

// File: rtl/qdt_prescale.sv
module qdt_prescale #(
  parameter int unsigned MID_LOG2  = 4,
  parameter int unsigned SLOW_LOG2 = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  logic       restart_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);

  logic [SLOW_LOG2-1:0] pcnt_q, pcnt_d;
  logic                 wrap_mid, wrap_slow;

  assign wrap_mid  = &pcnt_q[MID_LOG2-1:0];
  assign wrap_slow = &pcnt_q;

  always_comb begin
    if (restart_i || !run_i) pcnt_d = '0;
    else                     pcnt_d = pcnt_q + 1'b1;
  end

  always_comb begin
    tick_o = 1'b0;
    if (run_i && !restart_i) begin
      unique case (sel_i)
        2'b00:   tick_o = 1'b1;
        2'b01:   tick_o = wrap_mid;
        default: tick_o = wrap_slow;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

endmodule

// File: rtl/qdt_channel.sv
module qdt_channel
  import qdt_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_start_i,
  input  logic              wr_ctrl_i,
  input  logic              wr_staged_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] count_o,
  output logic [DATA_W-1:0] staged_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              fire_o
);

  localparam logic [DATA_W-1:0] NARROW_MASK =
    {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [DATA_W-1:0] count_q, count_d, staged_q, staged_d, wmask;
  ctrl_t             ctrl_q, ctrl_d;
  logic              tick, at_zero, count_en, staged_en, ctrl_en;

  qdt_prescale u_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (ctrl_q.en),
    .restart_i(wr_start_i | wr_ctrl_i),
    .sel_i    (ctrl_q.presc),
    .tick_o   (tick)
  );

  assign wmask   = ctrl_q.wide ? '1 : NARROW_MASK;
  assign at_zero = (count_q & wmask) == '0;

  always_comb begin
    count_d  = count_q;
    staged_d = staged_q;
    ctrl_d   = ctrl_q;
    fire_o   = 1'b0;
    if (tick) begin
      if (at_zero) begin
        fire_o = 1'b1;
        if (ctrl_q.oneshot) begin
          count_d   = '0;
          ctrl_d.en = 1'b0;
        end else if (ctrl_q.periodic) begin
          count_d = staged_q & wmask;
        end else begin
          count_d = wmask;
        end
      end else begin
        count_d = (count_q - 1'b1) & wmask;
      end
    end
    if (wr_ctrl_i) begin
      ctrl_d.en       = wdata_i[CB_EN];
      ctrl_d.periodic = wdata_i[CB_PER];
      ctrl_d.presc    = wdata_i[CB_PSHI:CB_PSLO];
      ctrl_d.wide     = wdata_i[CB_WIDE];
      ctrl_d.oneshot  = wdata_i[CB_ONE];
    end
    if (wr_start_i) begin
      count_d  = wdata_i;
      staged_d = wdata_i;
    end
    if (wr_staged_i) staged_d = wdata_i;
  end

  assign count_en  = tick | wr_start_i;
  assign staged_en = wr_start_i | wr_staged_i;
  assign ctrl_en   = wr_ctrl_i | fire_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      staged_q <= '0;
      ctrl_q   <= '0;
    end else begin
      if (count_en)  count_q  <= count_d;
      if (staged_en) staged_q <= staged_d;
      if (ctrl_en)   ctrl_q   <= ctrl_d;
    end
  end

  assign count_o  = count_q & wmask;
  assign staged_o = staged_q;
  assign ctrl_o   = {ctrl_q.en, ctrl_q.periodic, 2'b00, ctrl_q.presc,
                     ctrl_q.wide, ctrl_q.oneshot};

endmodule

// File: rtl/qdt_irq.sv
module qdt_irq #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] fire_i,
  input  logic              wr_mask_i,
  input  logic              wr_clear_i,
  input  logic [NUM_CH-1:0] wdata_i,
  output logic [NUM_CH-1:0] raw_o,
  output logic [NUM_CH-1:0] mask_o,
  output logic [NUM_CH-1:0] masked_o,
  output logic              irq_o
);

  logic [NUM_CH-1:0] raw_q, raw_d, mask_q, clr_bits;

  assign clr_bits = wr_clear_i ? wdata_i : '0;
  assign raw_d    = (raw_q & ~clr_bits) | fire_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= raw_d;
      if (wr_mask_i) mask_q <= wdata_i;
    end
  end

  assign raw_o    = raw_q;
  assign mask_o   = mask_q;
  assign masked_o = raw_q & mask_q;
  assign irq_o    = |masked_o;

endmodule

// File: rtl/quad_dcount_timer.sv
module quad_dcount_timer
  import qdt_pkg::*;
#(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NARROW_W = 16,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);

  localparam int unsigned BLK_W = ADDR_W - 4;

  logic [BLK_W-1:0]  blk;
  logic [1:0]        sub;
  logic              aligned, irq_hit, wr_mask, wr_clear;
  logic [DATA_W-1:0] ch_count  [NUM_CH];
  logic [DATA_W-1:0] ch_staged [NUM_CH];
  logic [CTRL_W-1:0] ch_ctrl   [NUM_CH];
  logic [NUM_CH-1:0] ch_fire, ch_en_v, ch_one_v, wr_start_v, wr_ctrl_v, wr_staged_v;
  logic [NUM_CH-1:0] raw, mask, masked;
  logic [DATA_W-1:0] rd_d, rd_q;

  assign blk      = bus_addr[ADDR_W-1:4];
  assign sub      = bus_addr[3:2];
  assign aligned  = bus_addr[1:0] == 2'b00;
  assign irq_hit  = aligned && (blk == '0);
  assign wr_mask  = bus_we && irq_hit && (sub == IR_MASK);
  assign wr_clear = bus_we && irq_hit && (sub == IR_CLEAR);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit            = bus_we && aligned && (blk == BLK_W'(g + 1));
    assign wr_start_v[g]  = hit && (sub == CH_START);
    assign wr_ctrl_v[g]   = hit && (sub == CH_CTRL);
    assign wr_staged_v[g] = hit && (sub == CH_STAGED);

    qdt_channel #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_start_i (wr_start_v[g]),
      .wr_ctrl_i  (wr_ctrl_v[g]),
      .wr_staged_i(wr_staged_v[g]),
      .wdata_i    (bus_wdata),
      .count_o    (ch_count[g]),
      .staged_o   (ch_staged[g]),
      .ctrl_o     (ch_ctrl[g]),
      .fire_o     (ch_fire[g])
    );
    assign ch_en_v[g]  = ch_ctrl[g][CB_EN];
    assign ch_one_v[g] = ch_ctrl[g][CB_ONE];
  end

  qdt_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire_i    (ch_fire),
    .wr_mask_i (wr_mask),
    .wr_clear_i(wr_clear),
    .wdata_i   (bus_wdata[NUM_CH-1:0]),
    .raw_o     (raw),
    .mask_o    (mask),
    .masked_o  (masked),
    .irq_o     (irq_o)
  );

  always_comb begin
    rd_d = '0;
    if (irq_hit) begin
      unique case (sub)
        IR_MASK:   rd_d = DATA_W'(mask);
        IR_RAW:    rd_d = DATA_W'(raw);
        IR_MASKED: rd_d = DATA_W'(masked);
        default:   rd_d = '0;
      endcase
    end else if (aligned) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (blk == BLK_W'(c + 1)) begin
          unique case (sub)
            CH_START:  rd_d = ch_staged[c];
            CH_COUNT:  rd_d = ch_count[c];
            CH_CTRL:   rd_d = DATA_W'(ch_ctrl[c]);
            default:   rd_d = ch_staged[c];
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign bus_rdata = rd_q;

endmodule

// File: rtl/qdt_checker.sv
module qdt_checker #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_o,
  input logic              wr_mask,
  input logic              wr_clear,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [NUM_CH-1:0] ch_fire,
  input logic [NUM_CH-1:0] ch_en_v,
  input logic [NUM_CH-1:0] ch_one_v,
  input logic [NUM_CH-1:0] wr_start_v,
  input logic [NUM_CH-1:0] wr_ctrl_v,
  input logic [NUM_CH-1:0] raw,
  input logic [DATA_W-1:0] ch_count [NUM_CH]
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    a_r9_fire_sets_raw: assert property (@(posedge clk) disable iff (!rst_n)
      ch_fire[g] |=> raw[g]);

    a_r9_clear_drops_raw: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clear && bus_wdata[g] && !ch_fire[g]) |=> !raw[g]);

    a_r6_oneshot_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_fire[g] && ch_one_v[g] && !wr_ctrl_v[g]) |=> !ch_en_v[g]);

    a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_en_v[g] && !wr_start_v[g] && !wr_ctrl_v[g]) |=> $stable(ch_count[g]));

    a_r3_fire_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      ch_fire[g] |-> ch_en_v[g]);
  end

  a_r10_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past((|ch_fire) || wr_mask));

endmodule

bind quad_dcount_timer qdt_checker #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_o     (irq_o),
  .wr_mask   (wr_mask),
  .wr_clear  (wr_clear),
  .bus_wdata (bus_wdata),
  .ch_fire   (ch_fire),
  .ch_en_v   (ch_en_v),
  .ch_one_v  (ch_one_v),
  .wr_start_v(wr_start_v),
  .wr_ctrl_v (wr_ctrl_v),
  .raw       (raw),
  .ch_count  (ch_count)
);

// File: tb/quad_dcount_timer_tb_top.sv
module quad_dcount_timer_tb_top;

  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  quad_dcount_timer dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq_o    (irq_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] ca(input int c, input int r);
    return 8'(16 + 16 * c + 4 * r);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  // Expected count after m ticks: start n, staged b, mode 0 single-shot, 1 periodic, 2 free
  function automatic longint unsigned expv(input int mode, input bit wide,
      input longint unsigned n, input longint unsigned b, input longint unsigned m);
    longint unsigned top, r;
    top = wide ? 64'hFFFF_FFFF : 64'hFFFF;
    if (m <= n) return n - m;
    r = m - n - 1;
    if (mode == 0) return 0;
    if (mode == 1) return b - (r % (b + 1));
    return top - (r % (top + 1));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    chk("R11 irq low", 32'(irq_o), 0);
    rd(8'h00, d); chk("R11 mask", d, 0);
    rd(8'h04, d); chk("R11 raw", d, 0);
    rd(8'h08, d); chk("R11 masked", d, 0);
    rd(ca(0, 1), d); chk("R11 count0", d, 0);
    rd(ca(3, 2), d); chk("R11 ctrl3", d, 0);

    // R1 control layout and readback
    wr(ca(2, 2), 32'h0000_004E); rd(ca(2, 2), d); chk("R1 ctrl readback", d, 32'h4E);
    wr(ca(2, 2), 32'hFFFF_FF7F); rd(ca(2, 2), d); chk("R1 ctrl undefined bits", d, 32'h4F);
    wr(ca(2, 2), 32'h0);
    // R2 start write sets count and staged
    wr(ca(1, 0), 32'h0000_1234);
    rd(ca(1, 0), d); chk("R2 start reads staged", d, 32'h1234);
    rd(ca(1, 3), d); chk("R2 staged", d, 32'h1234);
    rd(ca(1, 1), d); chk("R2 count", d, 32'h1234);

    // R8 narrow width, R7 idle hold, R4 staged write leaves count
    wr(ca(1, 0), 32'hABCD_0005);
    rd(ca(1, 1), d); chk("R8 narrow read", d, 32'h5);
    repeat (40) @(negedge clk);
    rd(ca(1, 1), d); chk("R7 idle holds", d, 32'h5);
    wr(ca(1, 2), 32'h2);
    rd(ca(1, 1), d); chk("R8 wide read", d, 32'hABCD_0005);
    wr(ca(1, 3), 32'h7);
    rd(ca(1, 1), d); chk("R4 staged write leaves count", d, 32'hABCD_0005);
    wr(ca(1, 2), 32'h0);

    // R10 / R9 mask, masked, clear, ignored writes
    wr(ca(3, 0), 32'h0);
    wr(ca(3, 2), 32'h81);
    repeat (4) @(negedge clk);
    wr(8'h00, 32'h7);
    chk("R10 masked-off irq", 32'(irq_o), 0);
    rd(8'h04, d); chk("R9 raw bit3", d, 32'h8);
    rd(8'h08, d); chk("R10 masked off", d, 32'h0);
    wr(8'h00, 32'h8);
    chk("R10 irq high", 32'(irq_o), 1);
    rd(8'h08, d); chk("R10 masked on", d, 32'h8);
    wr(8'h04, 32'h0); wr(8'h08, 32'h0);
    rd(8'h04, d); chk("R9 raw write ignored", d, 32'h8);
    wr(8'h0C, 32'h8);
    rd(8'h04, d); chk("R9 cleared", d, 32'h0);
    chk("R10 irq low after clear", 32'(irq_o), 0);
    wr(ca(3, 2), 32'h0);
    wr(8'h00, 32'hF);

    // Sweep: R3 R4 R5 R6 R8 over channel, mode, width, prescale, window
    for (int c = 0; c < 4; c++)
      for (int mode = 0; mode < 3; mode++)
        for (int w = 0; w < 2; w++)
          for (int ps = 0; ps < 3; ps++)
            for (int mi = 0; mi < 3; mi++) begin
              int n, b, m, dv;
              logic [31:0] cw;
              longint unsigned e;
              if (ps == 2 && c != 0) continue;
              n = 3; b = 2;
              m = (mi == 0) ? n : (mi == 1) ? n + 1 : n + 5;
              dv = (ps == 0) ? 1 : (ps == 1) ? 16 : 256;
              cw = 32'h80 | 32'(ps << 2) | (w ? 32'h2 : 32'h0) |
                   ((mode == 0) ? 32'h1 : (mode == 1) ? 32'h40 : 32'h0);
              wr(ca(c, 0), 32'(n));
              wr(ca(c, 3), 32'(b));
              wr(8'h0C, 32'hF);
              wr(ca(c, 2), cw);
              bus_addr = ca(c, 1);
              repeat (m * dv) @(negedge clk);
              chk($sformatf("R3 irq ch%0d mode%0d w%0d ps%0d m%0d", c, mode, w, ps, m),
                  32'(irq_o), (m > n) ? 1 : 0);
              @(negedge clk);
              e = expv(mode, w[0], n, b, m);
              chk($sformatf("%s count ch%0d w%0d ps%0d m%0d",
                  (mode == 0) ? "R6" : (mode == 1) ? "R4" : (w ? "R5" : "R8"),
                  c, w, ps, m), bus_rdata, 32'(e));
              if (mode == 0 && m > n) begin
                rd(ca(c, 2), d);
                chk($sformatf("R6 disarm ch%0d", c), d, cw & 32'h7F);
              end
              wr(ca(c, 2), 32'h0);
              wr(8'h0C, 32'hF);
              rd(8'h04, d);
              chk($sformatf("R9 clear ch%0d", c), d, 32'h0);
            end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule